// File: doc/BRIEF.md
# Indexed Command/Data Register Port

This block is a slave port through which a microprocessor reaches two small register banks over a 16-bit parallel bus with chip select, two address lines, separate read and write strobes and a bidirectional data bus. No register has a bus address of its own. The host first writes a register index to a bank's write-only command port. It then moves one or more 16-bit words through that bank's data port. A 32-bit register takes two data phases: the low half first, then the high half.

Each bank holds its own latched index and half-word phase, so accesses to the two banks may be interleaved freely. Strobes are synchronized to the internal clock. An access takes effect when the synchronized strobe is seen to release. Chip select, address and write data must therefore stay stable until a few clocks after the strobe goes high.

A 32-bit write is staged and committed as a whole when its second phase completes. A 32-bit read latches the upper half when the first phase completes, so both halves come from one snapshot.

Top module: `idx_reg_port`

## Requirements
- R1: `addr_i[1]` selects the bank (0 reaches bank 0, 1 reaches bank 1). `addr_i[0]` selects the port within that bank (0 is the data port, 1 is the command port). The two banks hold separate register contents.
- R2: A strobe has no effect while `cs_ni` is high.
- R3: A read of a command port returns 16'h0000.
- R4: A command write takes the index from bits [7:0] and ignores bits [15:8]. Indices 0x00 to 0x03 are 16-bit registers and 0x10 to 0x11 are 32-bit registers. All registers reset to zero.
- R5: A 16-bit register is read or written in a single data phase. Repeated data phases with no new command reach the same register.
- R6: A 32-bit register moves its bits [15:0] in the first data phase and bits [31:16] in the second. A write changes the register only when the second phase completes. After the second phase, the next data phase is again a low half.
- R7: A command write returns the bank's phase to the low half.
- R8: Index and phase are held per bank, so interleaved accesses to the other bank do not disturb an access sequence in progress.
- R9: A data access made before any command, or with an unmapped index, reads 16'h0000 and ignores writes.
- R10: `data_io` is driven only while `cs_ni` and `rd_ni` are both low. At all other times it is high-impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| addr_i | input | 2 | Bit 1 selects the bank, bit 0 selects the port (1 = command) |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_io | inout | 16 | Bidirectional data bus |

## Verification
The bench targets the 32-bit half-word sequence in three ways:
- It checks that a single low-half write leaves the register unchanged. A design that commits early would expose half-written values.
- It checks that a fresh command restarts at the low half. A design that kept the old phase would return the high half first.
- It checks that the phase wraps after the high half.

Interleaving the banks inside an unfinished 32-bit write catches shared index or phase state, which would corrupt the staged low half. Further cases cover reads and writes with no index, with an unmapped index, or while chip select is high. They also cover a command word with a nonzero upper byte, where a design that decoded all 16 bits would miss the register.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned N_REG16 = 4;
  localparam int unsigned N_REG32 = 2;
  localparam int unsigned BASE32  = 16;
  localparam int unsigned N_BANK  = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic done_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign level_o = sh_q[STAGES-1];
  // release of the synchronized strobe completes the access
  assign done_o  = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/idx_reg_bank.sv
module idx_reg_bank #(
  parameter int unsigned DATA_W  = idx_port_pkg::DATA_W,
  parameter int unsigned IDX_W   = idx_port_pkg::IDX_W,
  parameter int unsigned N_REG16 = idx_port_pkg::N_REG16,
  parameter int unsigned N_REG32 = idx_port_pkg::N_REG32,
  parameter int unsigned BASE32  = idx_port_pkg::BASE32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              phase_o,
  output logic              idx_vld_o
);
  localparam int unsigned S16_W = (N_REG16 > 1) ? $clog2(N_REG16) : 1;
  localparam int unsigned S32_W = (N_REG32 > 1) ? $clog2(N_REG32) : 1;

  logic [IDX_W-1:0]    idx_q;
  logic                vld_q;
  logic                phase_q;
  logic [DATA_W-1:0]   r16_q [N_REG16];
  logic [2*DATA_W-1:0] r32_q [N_REG32];
  logic [DATA_W-1:0]   lo_pend_q;
  logic [DATA_W-1:0]   hi_snap_q;

  logic             hit16, hit32;
  logic [IDX_W-1:0] off32;
  logic [S16_W-1:0] sel16;
  logic [S32_W-1:0] sel32;

  assign off32 = idx_q - IDX_W'(BASE32);
  assign hit16 = vld_q && (idx_q < IDX_W'(N_REG16));
  assign hit32 = vld_q && (idx_q >= IDX_W'(BASE32)) && (off32 < IDX_W'(N_REG32));
  assign sel16 = S16_W'(idx_q);
  assign sel32 = S32_W'(off32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      vld_q     <= 1'b0;
      phase_q   <= 1'b0;
      lo_pend_q <= '0;
      hi_snap_q <= '0;
    end else if (cmd_we_i) begin
      idx_q   <= wdata_i[IDX_W-1:0];
      vld_q   <= 1'b1;
      phase_q <= 1'b0;
    end else if (hit32 && (data_we_i || data_re_i)) begin
      phase_q <= ~phase_q;
      if (data_we_i && !phase_q) lo_pend_q <= wdata_i;
      if (data_re_i && !phase_q) hi_snap_q <= r32_q[sel32][2*DATA_W-1:DATA_W];
    end
  end

  for (genvar i = 0; i < N_REG16; i++) begin : gen_r16
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          r16_q[i] <= '0;
      else if (data_we_i && hit16 && sel16 == S16_W'(i))    r16_q[i] <= wdata_i;
    end
  end

  for (genvar j = 0; j < N_REG32; j++) begin : gen_r32
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r32_q[j] <= '0;
      else if (data_we_i && hit32 && phase_q && sel32 == S32_W'(j))
        r32_q[j] <= {wdata_i, lo_pend_q};
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit16)               rdata_o = r16_q[sel16];
    else if (hit32 && phase_q) rdata_o = hi_snap_q;
    else if (hit32)          rdata_o = r32_q[sel32][DATA_W-1:0];
  end

  assign phase_o   = phase_q;
  assign idx_vld_o = vld_q;
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
  parameter int unsigned DATA_W      = idx_port_pkg::DATA_W,
  parameter int unsigned N_BANK      = idx_port_pkg::N_BANK,
  parameter int unsigned SYNC_STAGES = idx_port_pkg::SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [1:0]        addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  inout  wire  [DATA_W-1:0] data_io
);
  logic wr_lvl, wr_done, rd_lvl, rd_done;
  logic [1:0]        cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [N_BANK-1:0][DATA_W-1:0] bank_rdata;
  logic [N_BANK-1:0] bank_phase, bank_vld;
  logic [DATA_W-1:0] rd_word;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(~cs_ni & ~wr_ni),
    .level_o(wr_lvl), .done_o(wr_done)
  );
  strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(~cs_ni & ~rd_ni),
    .level_o(rd_lvl), .done_o(rd_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (wr_lvl || rd_lvl) begin
      cap_addr <= addr_i;
      cap_data <= data_io;
    end
  end

  for (genvar b = 0; b < N_BANK; b++) begin : gen_bank
    logic hit_b;
    assign hit_b = (cap_addr[1] == b[0]);
    idx_reg_bank #(.DATA_W(DATA_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_we_i (wr_done & hit_b & cap_addr[0]),
      .data_we_i(wr_done & hit_b & ~cap_addr[0]),
      .data_re_i(rd_done & hit_b & ~cap_addr[0]),
      .wdata_i  (cap_data),
      .rdata_o  (bank_rdata[b]),
      .phase_o  (bank_phase[b]),
      .idx_vld_o(bank_vld[b])
    );
  end

  assign rd_word = addr_i[0] ? '0 : bank_rdata[addr_i[1]];
  assign data_io = (!cs_ni && !rd_ni) ? rd_word : 'z;
endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_ni,
  input logic        rd_ni,
  input logic [1:0]  addr_i,
  input logic [15:0] data_io,
  input logic        wr_done,
  input logic        rd_done,
  input logic [1:0]  cap_addr,
  input logic [1:0][15:0] bank_rdata,
  input logic [1:0]  bank_phase,
  input logic [1:0]  bank_vld
);
  AST_CMD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && addr_i[0]) |-> data_io == 16'h0000); // R3

  AST_CMD_CLEARS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done && cap_addr[0]) |=> bank_phase[cap_addr[1]] == 1'b0); // R7

  AST_NO_IDX_B0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_vld[0] |-> bank_rdata[0] == 16'h0000); // R9

  AST_NO_IDX_B1_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_vld[1] |-> bank_rdata[1] == 16'h0000); // R9

  AST_BANK0_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_done || rd_done) && cap_addr[1]) |=> $stable(bank_phase[0])); // R8

  AST_BANK1_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_done || rd_done) && !cap_addr[1]) |=> $stable(bank_phase[1])); // R8
endmodule

bind idx_reg_port idx_reg_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
  .addr_i(addr_i), .data_io(data_io), .wr_done(wr_done), .rd_done(rd_done),
  .cap_addr(cap_addr), .bank_rdata(bank_rdata), .bank_phase(bank_phase),
  .bank_vld(bank_vld)
);

// File: tb/idx_reg_port_test.sv
module idx_reg_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [15:0] drv = '0;
  logic drv_en = 1'b0;
  wire  [15:0] data;
  int n_chk = 0, n_fail = 0;

  assign data = drv_en ? drv : 'z;
  always #10 clk = ~clk;

  idx_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .addr_i(addr),
    .rd_ni(rd_n), .wr_ni(wr_n), .data_io(data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit bank, input bit cmd, input logic [15:0] val, input bit cs_on = 1'b1);
    @(negedge clk);
    addr = {bank, cmd}; cs_n = ~cs_on; drv = val; drv_en = 1'b1;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1; drv_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input bit bank, input bit cmd, output logic [15:0] val);
    @(negedge clk);
    addr = {bank, cmd}; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (5) @(negedge clk);
    val = data;
    @(negedge clk);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R10 idle bus", data, 16'hzzzz);
    bus_rd(1'b0, 1'b1, v); check("R3 cmd port read", v, 16'h0000);
    bus_rd(1'b1, 1'b0, v); check("R9 read before command", v, 16'h0000);
  endtask

  task automatic t_reg16;
    logic [15:0] v;
    bus_wr(1'b0, 1'b1, 16'h0002);
    bus_wr(1'b0, 1'b0, 16'hA5A5);
    bus_rd(1'b0, 1'b0, v); check("R5 16-bit read", v, 16'hA5A5);
    bus_rd(1'b0, 1'b0, v); check("R5 repeated read", v, 16'hA5A5);
    bus_wr(1'b0, 1'b1, 16'hFF01);
    bus_wr(1'b0, 1'b0, 16'h1234);
    bus_wr(1'b0, 1'b1, 16'h0001);
    bus_rd(1'b0, 1'b0, v); check("R4 upper byte ignored", v, 16'h1234);
    bus_rd(1'b0, 1'b1, v); check("R3 cmd port after write", v, 16'h0000);
  endtask

  task automatic t_reg32;
    logic [15:0] v;
    bus_wr(1'b1, 1'b1, 16'h0010);
    bus_wr(1'b1, 1'b0, 16'h5678);
    bus_wr(1'b1, 1'b1, 16'h0010);
    bus_rd(1'b1, 1'b0, v); check("R6 no commit on low half", v, 16'h0000);
    bus_rd(1'b1, 1'b0, v); check("R6 high half still zero", v, 16'h0000);
    bus_wr(1'b1, 1'b1, 16'h0010);
    bus_wr(1'b1, 1'b0, 16'h5678);
    bus_wr(1'b1, 1'b0, 16'hDEAD);
    bus_wr(1'b1, 1'b1, 16'h0010);
    bus_rd(1'b1, 1'b0, v); check("R6 low half", v, 16'h5678);
    bus_rd(1'b1, 1'b0, v); check("R6 high half", v, 16'hDEAD);
    bus_rd(1'b1, 1'b0, v); check("R6 phase wraps to low", v, 16'h5678);
  endtask

  task automatic t_phase_reset;
    logic [15:0] v;
    bus_wr(1'b1, 1'b1, 16'h0010);
    bus_rd(1'b1, 1'b0, v);
    bus_wr(1'b1, 1'b1, 16'h0010);
    bus_rd(1'b1, 1'b0, v); check("R7 command restarts low half", v, 16'h5678);
  endtask

  task automatic t_interleave;
    logic [15:0] v;
    bus_wr(1'b0, 1'b1, 16'h0011);
    bus_wr(1'b1, 1'b1, 16'h0000);
    bus_wr(1'b0, 1'b0, 16'h1111);
    bus_wr(1'b1, 1'b0, 16'h2222);
    bus_wr(1'b0, 1'b0, 16'h3333);
    bus_rd(1'b1, 1'b0, v); check("R8 bank1 16-bit intact", v, 16'h2222);
    bus_wr(1'b0, 1'b1, 16'h0011);
    bus_rd(1'b0, 1'b0, v); check("R8 bank0 low half", v, 16'h1111);
    bus_rd(1'b0, 1'b0, v); check("R8 bank0 high half", v, 16'h3333);
    bus_wr(1'b0, 1'b1, 16'h0000);
    bus_rd(1'b0, 1'b0, v); check("R1 banks separate", v, 16'h0000);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    bus_wr(1'b0, 1'b1, 16'h0005);
    bus_wr(1'b0, 1'b0, 16'hFFFF);
    bus_rd(1'b0, 1'b0, v); check("R9 unmapped index", v, 16'h0000);
  endtask

  task automatic t_cs_high;
    logic [15:0] v;
    bus_wr(1'b0, 1'b1, 16'h0003);
    bus_wr(1'b0, 1'b0, 16'h0F0F);
    bus_wr(1'b0, 1'b0, 16'hBEEF, 1'b0);
    bus_rd(1'b0, 1'b0, v); check("R2 write with cs high ignored", v, 16'h0F0F);
    @(negedge clk);
    addr = 2'b00; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 no drive with cs high", data, 16'hzzzz);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_reg16();
    t_reg32();
    t_phase_reset();
    t_interleave();
    t_unmapped();
    t_cs_high();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule